// File: doc/BRIEF.md
# Keyed flash programming controller

This block sits between a processor's register port and the command interface of an internal flash array. It keeps word-program and page-erase operations from starting by accident. Software loads a target address and a data word, picks an operation, arms a write-enable bit, writes a fixed three-value key sequence to a dedicated key register and then sets a start bit. Only when every one of these steps has been taken in order does the controller send a single-cycle command to the array. It then holds a busy flag until the array reports that it is done.

The register port has four 32-bit registers: control, key, address and data. Control, address and data can each be written whole, or have bits set or cleared through alias offsets. When an operation ends, the array's error indications are latched into sticky flags in the control register. The controller checks alignment and operation codes on its own side before any command goes out, and it rounds erase addresses down to the start of a page of configurable size.

Top module: `flash_prog_ctrl`

## Requirements
- R1: After reset every register reads as zero, rsp_rdata is zero and cmd_valid is low.
- R2: The register offset is {reg[1:0], alias[1:0], 2'b00} with reg 0 = control, 1 = key, 2 = address, 3 = data and alias 0 = write whole value, 1 = OR in the set bits, 2 = AND out the set bits. A read of any alias of a register returns that register one cycle after the request. Writes with alias 3 are ignored. Key reads return zero.
- R3: A start attempt counts only when the key register's three most recent writes were 0x00000000, 0xAA996655 and 0x556699AA, in that order, and the control write that sets bit 15 is the next access after the last key.
- R4: Any key write that does not fit the expected sequence sends the sequencer back to idle (a zero key restarts it at the first step). Any other access between key writes also sends it back to idle. The unlock is used up by the first access after it, whatever that access is.
- R5: A start attempt does nothing unless write enable (control bit 14) was already set before the start write and stays set by it.
- R6: Control bits [3:0] select the operation: 0 = no operation, 1 = word write, 4 = page erase. An accepted word write or page erase raises cmd_valid for exactly one cycle, carrying the operation code, the address and the data register.
- R7: Control bit 15 reads as one from the cycle after an accepted command until the cycle in which array_done is high, and it clears then.
- R8: When array_done is seen, array_wr_err and array_lv_err are ORed into control bits 13 and 12. These flags stay set until a no-operation start is accepted or a control write leaves write enable at zero.
- R9: A page erase sends the address register value with its low log2(PAGE_BYTES) bits forced to zero.
- R10: A word write whose address has a nonzero low two bits, or any operation code other than 0, 1 or 4, sets control bit 13 and sends no command.
- R11: While bit 15 is high, writes to control, address and data have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register access this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 6 | Byte offset: register and alias |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, registered, valid the cycle after a read |
| cmd_valid | output | 1 | One-cycle command strobe to the array |
| cmd_op | output | 4 | Operation code of the command |
| cmd_addr | output | 32 | Target address (page-aligned for erase) |
| cmd_data | output | 32 | Word to program |
| array_done | input | 1 | Array finished the current command |
| array_wr_err | input | 1 | Array refused the write (protected region) |
| array_lv_err | input | 1 | Array saw low supply during the operation |

## Verification
On every cycle the assertions check the following. The command strobe lasts one cycle and only shows up while busy. Word-write commands are aligned and erase commands are page-aligned. Busy holds until the array reports done. Busy rises only straight after an open unlock, and any access after an open unlock locks it again. The address and data registers stay frozen during an operation. Whether a given key sequence, write-enable history and operation code actually start an operation, what gets latched as an error, and when the sticky flags clear can only be shown by the bench's register-level scenarios. That includes the full sweep of operation codes against address alignments and the interrupted or wrong key sequences.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

  localparam int BUS_W = 32;
  localparam int OFF_W = 6;
  localparam int OP_W  = 4;

  localparam logic [OP_W-1:0] OP_NOP   = 4'd0;
  localparam logic [OP_W-1:0] OP_WORD  = 4'd1;
  localparam logic [OP_W-1:0] OP_ERASE = 4'd4;

  localparam int BIT_GO   = 15;
  localparam int BIT_WREN = 14;
  localparam int BIT_WERR = 13;
  localparam int BIT_LERR = 12;

  localparam logic [BUS_W-1:0] KEY_ZERO = 32'h0000_0000;
  localparam logic [BUS_W-1:0] KEY_ONE  = 32'hAA99_6655;
  localparam logic [BUS_W-1:0] KEY_TWO  = 32'h5566_99AA;

  typedef enum logic [1:0] {
    RG_CTRL = 2'd0,
    RG_KEY  = 2'd1,
    RG_ADDR = 2'd2,
    RG_DATA = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    AL_ALL = 2'd0,
    AL_SET = 2'd1,
    AL_CLR = 2'd2,
    AL_RSV = 2'd3
  } alias_e;

  typedef enum logic [1:0] {
    KS_IDLE = 2'd0,
    KS_GOT0 = 2'd1,
    KS_GOT1 = 2'd2,
    KS_OPEN = 2'd3
  } key_st_e;

  function automatic logic [BUS_W-1:0] alias_apply(input logic [BUS_W-1:0] cur,
                                                   input logic [BUS_W-1:0] wd,
                                                   input alias_e           al);
    logic [BUS_W-1:0] r;
    case (al)
      AL_ALL:  r = wd;
      AL_SET:  r = cur | wd;
      AL_CLR:  r = cur & ~wd;
      default: r = cur;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/fpc_decode.sv
module fpc_decode
  import fpc_pkg::*;
(
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [OFF_W-1:0] req_addr,
  output logic             acc,
  output logic             rd_en,
  output logic             wr_ok,
  output logic             key_wr,
  output reg_sel_e         sel,
  output alias_e           al
);

  logic [1:0] unused_low;

  assign unused_low = req_addr[1:0];
  assign sel    = reg_sel_e'(req_addr[5:4]);
  assign al     = alias_e'(req_addr[3:2]);
  assign acc    = req_valid;
  assign rd_en  = req_valid && !req_write;
  // key writes take the raw value through any alias
  assign key_wr = req_valid && req_write && (sel == RG_KEY);
  // writes to control, address, data with a usable alias
  assign wr_ok  = req_valid && req_write && (al != AL_RSV) && (sel != RG_KEY);

endmodule

// File: rtl/fpc_unlock.sv
module fpc_unlock
  import fpc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             acc,
  input  logic             key_wr,
  input  logic [BUS_W-1:0] wdata,
  output logic             unlocked
);

  key_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (key_wr) begin
      if (wdata == KEY_ZERO)                         st_d = KS_GOT0;
      else if (st_q == KS_GOT0 && wdata == KEY_ONE)  st_d = KS_GOT1;
      else if (st_q == KS_GOT1 && wdata == KEY_TWO)  st_d = KS_OPEN;
      else                                           st_d = KS_IDLE;
    end else if (acc) begin
      st_d = KS_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= KS_IDLE;
    else     st_q <= st_d;
  end

  assign unlocked = (st_q == KS_OPEN);

  // R3: the open state is reached only by the final key value
  p_open_after_key_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(unlocked) |-> $past(key_wr && wdata == KEY_TWO));

  // R4: whatever access follows an open unlock relocks it
  p_single_use_r4: assert property (@(posedge clk) disable iff (rst)
    unlocked && acc |=> !unlocked);

endmodule

// File: rtl/fpc_engine.sv
module fpc_engine
  import fpc_pkg::*;
#(
  parameter int PAGE_BYTES = 1024
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             ctrl_wr,
  input  logic [BUS_W-1:0] ctrl_nv,
  input  logic             unlocked,
  input  logic [BUS_W-1:0] addr_q,
  input  logic [BUS_W-1:0] data_q,
  input  logic             array_done,
  input  logic             array_wr_err,
  input  logic             array_lv_err,
  output logic             busy,
  output logic [BUS_W-1:0] ctrl_word,
  output logic             cmd_valid,
  output logic [OP_W-1:0]  cmd_op,
  output logic [BUS_W-1:0] cmd_addr,
  output logic [BUS_W-1:0] cmd_data
);

  localparam int PAGE_LSB = $clog2(PAGE_BYTES);
  localparam logic [BUS_W-1:0] PAGE_MASK = ~((BUS_W'(1) << PAGE_LSB) - BUS_W'(1));

  logic            busy_q, wren_q, werr_q, lerr_q;
  logic [OP_W-1:0] op_q;
  logic            cv_q;
  logic [OP_W-1:0] cop_q;
  logic [BUS_W-1:0] cad_q, cdt_q;

  logic [OP_W-1:0] nv_op;
  logic            nv_wren, nv_go;
  logic            start_try, do_launch, do_flag, do_nop;
  logic [BUS_W-1:0] launch_addr;
  logic            unused_nv;

  assign nv_op     = ctrl_nv[OP_W-1:0];
  assign nv_wren   = ctrl_nv[BIT_WREN];
  assign nv_go     = ctrl_nv[BIT_GO];
  assign unused_nv = ^{ctrl_nv[BUS_W-1:16], ctrl_nv[BIT_WERR:OP_W]};

  assign start_try = ctrl_wr && !busy_q && nv_go && nv_wren && wren_q && unlocked;

  always_comb begin
    do_launch   = 1'b0;
    do_flag     = 1'b0;
    do_nop      = 1'b0;
    launch_addr = addr_q;
    case (nv_op)
      OP_NOP:   do_nop = 1'b1;
      OP_WORD:  if (addr_q[1:0] == 2'b00) do_launch = 1'b1;
                else                      do_flag   = 1'b1;
      OP_ERASE: begin
        do_launch   = 1'b1;
        launch_addr = addr_q & PAGE_MASK;
      end
      default:  do_flag = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      wren_q <= 1'b0;
      werr_q <= 1'b0;
      lerr_q <= 1'b0;
      op_q   <= '0;
      cv_q   <= 1'b0;
      cop_q  <= '0;
      cad_q  <= '0;
      cdt_q  <= '0;
    end else begin
      cv_q <= 1'b0;
      if (busy_q) begin
        if (array_done) begin
          busy_q <= 1'b0;
          werr_q <= werr_q | array_wr_err;
          lerr_q <= lerr_q | array_lv_err;
        end
      end else if (ctrl_wr) begin
        op_q   <= nv_op;
        wren_q <= nv_wren;
        if (!nv_wren) begin
          werr_q <= 1'b0;
          lerr_q <= 1'b0;
        end
        if (start_try) begin
          if (do_nop) begin
            werr_q <= 1'b0;
            lerr_q <= 1'b0;
          end
          if (do_flag) werr_q <= 1'b1;
          if (do_launch) begin
            busy_q <= 1'b1;
            cv_q   <= 1'b1;
            cop_q  <= nv_op;
            cad_q  <= launch_addr;
            cdt_q  <= data_q;
          end
        end
      end
    end
  end

  assign busy      = busy_q;
  assign cmd_valid = cv_q;
  assign cmd_op    = cop_q;
  assign cmd_addr  = cad_q;
  assign cmd_data  = cdt_q;
  assign ctrl_word = {16'h0000, busy_q, wren_q, werr_q, lerr_q, 8'h00, op_q};

  // R6: the strobe lasts a single cycle
  p_strobe_single_r6: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> !cmd_valid);

  // R7: a strobe only appears while the operation is in flight
  p_strobe_busy_r7: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> busy);

  // R7: busy holds until the array answers
  p_busy_hold_r7: assert property (@(posedge clk) disable iff (rst)
    busy && !array_done |=> busy);

  // R3: an operation starts only right after an open unlock
  p_go_needs_key_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(unlocked));

  // R10: word-write commands are always aligned
  p_word_aligned_r10: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_op == OP_WORD |-> cmd_addr[1:0] == 2'b00);

  // R9: erase commands point at a page boundary
  p_erase_page_r9: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_op == OP_ERASE |-> (cmd_addr & ~PAGE_MASK) == '0);

endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
  import fpc_pkg::*;
#(
  parameter int PAGE_BYTES = 1024
)(
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [5:0]  req_addr,
  input  logic [31:0] req_wdata,
  output logic [31:0] rsp_rdata,
  output logic        cmd_valid,
  output logic [3:0]  cmd_op,
  output logic [31:0] cmd_addr,
  output logic [31:0] cmd_data,
  input  logic        array_done,
  input  logic        array_wr_err,
  input  logic        array_lv_err
);

  logic             acc, rd_en, wr_ok, key_wr, unlocked, busy;
  reg_sel_e         sel;
  alias_e           al;
  logic [BUS_W-1:0] ctrl_word, ctrl_nv, addr_q, data_q, rd_q;

  fpc_decode u_dec (
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .acc       (acc),
    .rd_en     (rd_en),
    .wr_ok     (wr_ok),
    .key_wr    (key_wr),
    .sel       (sel),
    .al        (al)
  );

  fpc_unlock u_key (
    .clk      (clk),
    .rst      (rst),
    .acc      (acc),
    .key_wr   (key_wr),
    .wdata    (req_wdata),
    .unlocked (unlocked)
  );

  assign ctrl_nv = alias_apply(ctrl_word, req_wdata, al);

  fpc_engine #(.PAGE_BYTES(PAGE_BYTES)) u_eng (
    .clk          (clk),
    .rst          (rst),
    .ctrl_wr      (wr_ok && sel == RG_CTRL),
    .ctrl_nv      (ctrl_nv),
    .unlocked     (unlocked),
    .addr_q       (addr_q),
    .data_q       (data_q),
    .array_done   (array_done),
    .array_wr_err (array_wr_err),
    .array_lv_err (array_lv_err),
    .busy         (busy),
    .ctrl_word    (ctrl_word),
    .cmd_valid    (cmd_valid),
    .cmd_op       (cmd_op),
    .cmd_addr     (cmd_addr),
    .cmd_data     (cmd_data)
  );

  // address and data share one structure, frozen while busy
  for (genvar g = 0; g < 2; g++) begin : g_gp
    localparam reg_sel_e MY_SEL = (g == 0) ? RG_ADDR : RG_DATA;
    logic [BUS_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)                                  q <= '0;
      else if (wr_ok && sel == MY_SEL && !busy) q <= alias_apply(q, req_wdata, al);
    end
  end

  assign addr_q = g_gp[0].q;
  assign data_q = g_gp[1].q;

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else if (rd_en) begin
      case (sel)
        RG_CTRL: rd_q <= ctrl_word;
        RG_ADDR: rd_q <= addr_q;
        RG_DATA: rd_q <= data_q;
        default: rd_q <= '0;
      endcase
    end
  end

  assign rsp_rdata = rd_q;

  // R11: operands cannot move under a running operation
  p_addr_frozen_r11: assert property (@(posedge clk) disable iff (rst)
    $past(busy) && busy |-> $stable(addr_q));

  p_data_frozen_r11: assert property (@(posedge clk) disable iff (rst)
    $past(busy) && busy |-> $stable(data_q));

endmodule

// File: tb/flash_prog_ctrl_test.sv
`timescale 1ns/1ps
module flash_prog_ctrl_test;

  localparam int PAGE = 256;
  localparam logic [31:0] K1 = 32'hAA99_6655;
  localparam logic [31:0] K2 = 32'h5566_99AA;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [5:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rsp_rdata;
  logic        cmd_valid;
  logic [3:0]  cmd_op;
  logic [31:0] cmd_addr, cmd_data;
  logic        array_done = 1'b0, array_wr_err = 1'b0, array_lv_err = 1'b0;

  int total = 0, bad = 0, cmd_cnt = 0, resp_delay = 3;
  logic resp_werr = 1'b0, resp_lerr = 1'b0, finished = 1'b0;
  logic [3:0]  last_op;
  logic [31:0] last_addr, last_data;

  always #2 clk = ~clk;

  flash_prog_ctrl #(.PAGE_BYTES(PAGE)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .array_done(array_done), .array_wr_err(array_wr_err), .array_lv_err(array_lv_err)
  );

  // behavioural flash array
  initial begin
    forever begin
      @(negedge clk);
      if (cmd_valid) begin
        cmd_cnt++;
        last_op = cmd_op; last_addr = cmd_addr; last_data = cmd_data;
        repeat (resp_delay) @(negedge clk);
        array_done = 1'b1; array_wr_err = resp_werr; array_lv_err = resp_lerr;
        @(negedge clk);
        array_done = 1'b0; array_wr_err = 1'b0; array_lv_err = 1'b0;
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int r, input int al, input logic [31:0] v);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 6'(r*16 + al*4); req_wdata = v;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input int r, input int al, output logic [31:0] v);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 6'(r*16 + al*4);
    @(negedge clk);
    req_valid = 1'b0;
    v = rsp_rdata;
  endtask

  task automatic keys();
    wr(1, 0, 32'h0); wr(1, 0, K1); wr(1, 0, K2);
  endtask

  task automatic launch(input logic [3:0] op, input logic [31:0] a, input logic [31:0] d);
    wr(2, 0, a); wr(3, 0, d);
    wr(0, 0, {28'h0, op});
    wr(0, 1, 32'h4000);
    keys();
    wr(0, 1, 32'h8000);
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 200; i++) begin
      rd(0, 0, v);
      if (!v[15]) break;
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    summary();
  end

  initial begin
    logic [31:0] v, m, a, d, e;
    int c0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 rdata", rsp_rdata, 32'h0);
    rd(0, 0, v); check("R1 ctrl", v, 32'h0);
    rd(2, 0, v); check("R1 addr", v, 32'h0);
    rd(3, 0, v); check("R1 data", v, 32'h0);
    check("R1 no cmd", 32'(cmd_cnt), 32'h0);

    // R2 alias model on address and data
    for (int r = 2; r <= 3; r++) begin
      for (int p = 0; p < 4; p++) begin
        m = 32'h1357_9BDF ^ (32'(p) * 32'h0F0F_1111);
        wr(r, 0, m);                 rd(r, 0, v); check("R2 whole", v, m);
        wr(r, 1, 32'hF000_000F);     m = m | 32'hF000_000F; rd(r, 1, v); check("R2 set", v, m);
        wr(r, 2, 32'h0FF0_FF00 >> p); m = m & ~(32'h0FF0_FF00 >> p); rd(r, 2, v); check("R2 clr", v, m);
        wr(r, 3, 32'hFFFF_FFFF);     rd(r, 0, v); check("R2 rsv ignored", v, m);
      end
    end
    wr(0, 0, 32'h4); wr(0, 1, 32'h4000); rd(0, 0, v); check("R2 ctrl set", v, 32'h4004);
    wr(0, 2, 32'h4000); rd(0, 0, v); check("R2 ctrl clr", v, 32'h0004);
    rd(1, 0, v); check("R2 key reads zero", v, 32'h0);

    // R3 R6 R9 R10 sweep of op codes against address alignment
    for (int op = 0; op < 8; op++) begin
      for (int lo = 0; lo < 4; lo++) begin
        logic issue, err;
        a = 32'h0003_5A70 + 32'(op * 32'h1C4) + 32'(lo);
        d = 32'hD000_0000 | 32'(op * 16 + lo);
        issue = (op == 1 && lo == 0) || (op == 4);
        err = !issue && (op != 0);
        c0 = cmd_cnt;
        launch(4'(op), a, d);
        wait_idle();
        check(issue ? "R6 cmd issued" : "R10 no cmd", 32'(cmd_cnt - c0), issue ? 32'h1 : 32'h0);
        if (issue) begin
          e = (op == 4) ? (a & ~32'(PAGE - 1)) : a;
          check("R6 cmd op", 32'(last_op), 32'(op));
          check(op == 4 ? "R9 erase addr" : "R6 cmd addr", last_addr, e);
          check("R6 cmd data", last_data, d);
        end
        rd(0, 0, v);
        check("R10 ctrl after op", v, 32'h4000 | (err ? 32'h2000 : 32'h0) | 32'(op));
      end
    end

    // R9 extra erase addresses
    for (int k = 0; k < 6; k++) begin
      a = 32'h1000_0000 + 32'(k * 333);
      launch(4'd4, a, 32'h0);
      wait_idle();
      check("R9 erase page", last_addr, a & ~32'(PAGE - 1));
    end

    // R7 R11 long operation
    resp_delay = 25;
    launch(4'd1, 32'h100, 32'hCAFE_0001);
    rd(0, 0, v); check("R7 busy high", v, 32'hC001);
    wr(2, 0, 32'h999); wr(3, 0, 32'h1234); wr(0, 0, 32'h4); wr(0, 2, 32'h4000);
    rd(2, 0, v); check("R11 addr held", v, 32'h100);
    rd(3, 0, v); check("R11 data held", v, 32'hCAFE_0001);
    rd(0, 0, v); check("R11 ctrl held", v, 32'hC001);
    wait_idle();
    rd(0, 0, v); check("R7 busy cleared", v, 32'h4001);
    resp_delay = 3;

    // R8 sticky errors
    resp_werr = 1'b1;
    launch(4'd1, 32'h200, 32'h5);
    wait_idle(); resp_werr = 1'b0;
    rd(0, 0, v); check("R8 wr err latched", v, 32'h6001);
    wr(2, 0, 32'h300); rd(0, 0, v); check("R8 sticky", v, 32'h6001);
    c0 = cmd_cnt;
    wr(0, 2, 32'hF); keys(); wr(0, 1, 32'h8000);
    rd(0, 0, v); check("R8 nop clears", v, 32'h4000);
    check("R8 nop no cmd", 32'(cmd_cnt - c0), 32'h0);
    resp_lerr = 1'b1;
    launch(4'd4, 32'h400, 32'h0);
    wait_idle(); resp_lerr = 1'b0;
    rd(0, 0, v); check("R8 lv err latched", v, 32'h5004);
    wr(0, 2, 32'h4000); rd(0, 0, v); check("R8 wren clear clears", v, 32'h0004);

    // R5 write enable required, R4 unlock used up
    c0 = cmd_cnt;
    wr(2, 0, 32'h40); wr(0, 0, 32'h1); keys(); wr(0, 1, 32'h8000);
    rd(0, 0, v); check("R5 no wren no start", v, 32'h0001);
    wr(0, 1, 32'h4000); wr(0, 1, 32'h8000);
    rd(0, 0, v); check("R4 unlock consumed", v, 32'h4001);
    check("R5 no cmd", 32'(cmd_cnt - c0), 32'h0);

    // R4 broken sequences
    wr(1, 0, 32'h0); wr(1, 0, K1); rd(2, 0, v); wr(1, 0, K2); wr(0, 1, 32'h8000);
    wr(1, 0, 32'h0); wr(1, 0, 32'h1234_5678); wr(1, 0, K2); wr(0, 1, 32'h8000);
    wr(1, 0, K1); wr(1, 0, K2); wr(0, 1, 32'h8000);
    rd(0, 0, v); check("R4 broken no start", v, 32'h4001);
    check("R4 broken no cmd", 32'(cmd_cnt - c0), 32'h0);

    // R3 zero key restarts the sequence
    wr(1, 0, 32'h0); wr(1, 0, K1); wr(1, 0, 32'h0); wr(1, 0, K1); wr(1, 0, K2);
    wr(0, 1, 32'h8000);
    wait_idle();
    check("R3 restart issues", 32'(cmd_cnt - c0), 32'h1);
    check("R3 restart addr", last_addr, 32'h40);

    summary();
  end

endmodule